// File: doc/BRIEF.md
# Multi-Channel Capture/Compare PWM Array

This block pairs one shared 16-bit timebase with a small set of capture/compare channels (three by default). The timebase advances on a selectable tick: every system clock, the system clock divided by one of two fixed ratios, or rising edges of an external tick input. Each channel owns one 16-bit register and one output pin. It can record the timebase on an input edge, raise a flag when the timebase reaches a programmed value, toggle its pin on that match, produce a square wave, or generate a pulse-width modulated waveform.

Channels are set up through a small write port that selects a channel and one of two per-channel registers: a mode word and the data value. PWM resolution is 8, 9, 10, 11 or 16 bits. The waveform can be edge-aligned or centre-aligned, and each pin can be inverted. A new PWM duty takes effect only at the start of the next PWM period. An asynchronous kill input drives every pin to its inactive level at once. Flags stay set until they are cleared.

Top module: `ccp_array`

## Requirements
- R1: `count` advances by one per tick while `run` is high and holds while `run` is low. `clk_sel` chooses the tick: 0 = every clock, 1 = every 4th clock, 2 = every 12th clock, 3 = each rising edge of `ext_tick` after a two-flop synchronizer. The divider counts only while `run` is high.
- R2: `ovf_flag` sets on the tick that takes `count` from 0xFFFF to 0, and it stays set until `ovf_clr` is pulsed.
- R3: The mode word has these fields: [2:0] mode (0 off, 1 capture, 2 timer, 3 toggle, 4 frequency, 5 PWM), [3] capture on rising edge, [4] capture on falling edge, [5] invert pin, [6] centre-align, [9:7] resolution code (0..3 = 8..11 bits, 4 = 16 bits). In capture mode an enabled edge on `cap_in` copies `count` into the channel value and sets the channel flag. With one tick per clock, the captured value is the count seen when the input changed, plus 2. Edges that are not enabled are ignored.
- R4: A channel flag stays set until its `flag_clr` bit is pulsed.
- R5: In timer mode the flag sets one cycle after `count` equals the channel value. With one tick per clock, it is first seen when `count` = value + 1.
- R6: In toggle mode the pin toggles on each match, one cycle after the match.
- R7: In frequency mode the pin toggles when the low byte of `count` equals the low byte of the value. The low byte of the value then advances by the high byte.
- R8: In edge-aligned n-bit PWM the raw output is active while (count mod 2^n) < (compare mod 2^n). A compare of 0 gives no active cycles.
- R9: In centre-aligned n-bit PWM, with m = compare mod 2^n, there are 2*floor(m/2) active cycles per 2^n, centred on the middle of the period.
- R10: In PWM mode a data write goes to a shadow register. The channel value takes the shadow value only in the cycle after the low n bits of `count` become 0.
- R11: Setting the invert bit inverts the pin. The inactive level is then 1.
- R12: While `kill` is high, every pin shows its inactive level, without waiting for a clock.
- R13: After reset, `count`, all flags and all pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Timebase enable |
| clk_sel | input | 2 | Tick source select |
| ext_tick | input | 1 | External tick input |
| kill | input | 1 | Asynchronous force-inactive input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 1 | 0 = mode word, 1 = data value |
| cfg_wdata | input | 16 | Write data |
| cap_in | input | NCH | Capture inputs, one per channel |
| flag_clr | input | NCH | Per-channel flag clear |
| ovf_clr | input | 1 | Overflow flag clear |
| count | output | 16 | Timebase value |
| ovf_flag | output | 1 | Timebase wrap flag |
| ch_flag | output | NCH | Channel flags |
| ch_out | output | NCH | Channel pins |
| ch_value | output | 16*NCH | Channel values, channel 0 in the low 16 bits |

## Verification
Some internal faults appear quickly at the ports. A wrong prescaler state changes `count` within one divide period. A bad capture synchronizer shifts the captured value by a whole cycle, and that shows on the very next edge. Other faults only show as statistics. A PWM comparison fault changes the number of active pin cycles over a full 2^n window, so each resolution and both alignments are swept and their cycle counts compared with closed-form duty values. A shadow-register fault shows as `ch_value` changing before or after the period boundary, so the exact boundary cycle is probed.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int TW = 16;

  typedef enum logic [2:0] {
    M_OFF  = 3'd0,
    M_CAPT = 3'd1,
    M_SWT  = 3'd2,
    M_HSO  = 3'd3,
    M_FREQ = 3'd4,
    M_PWM  = 3'd5
  } ch_mode_e;

  // resolution code to period mask
  function automatic logic [TW-1:0] pwm_mask(input logic [2:0] code);
    case (code)
      3'd0:    return 16'h00FF;
      3'd1:    return 16'h01FF;
      3'd2:    return 16'h03FF;
      3'd3:    return 16'h07FF;
      default: return 16'hFFFF;
    endcase
  endfunction

  // raw (pre-polarity) PWM level for a timebase value and compare value
  function automatic logic pwm_level(input logic [TW-1:0] c_in,
                                     input logic [TW-1:0] cmp,
                                     input logic [2:0]    code,
                                     input logic          center);
    logic [TW-1:0] mask, c, m, half, tri_v;
    logic [TW+1:0] lhs, rhs;
    mask  = pwm_mask(code);
    c     = c_in & mask;
    m     = cmp & mask;
    half  = (mask >> 1) + 16'd1;
    tri_v = ((c & half) != '0) ? (mask - c) : c;
    lhs   = {1'b0, tri_v, 1'b0} + {2'b00, m};
    rhs   = {2'b00, mask} + 18'd1;
    if (!center) return c < m;
    return lhs >= rhs;
  endfunction
endpackage

// File: rtl/ccp_timebase.sv
module ccp_timebase
  import ccp_pkg::*;
#(
  parameter int PRE_A = 4,
  parameter int PRE_B = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    clk_sel,
  input  logic          ext_tick,
  input  logic          ovf_clr,
  output logic [TW-1:0] cnt,
  output logic          adv,
  output logic          ovf_flag
);
  localparam int DW = $clog2(PRE_B);

  logic [DW-1:0] div_q, limit;
  logic          e1, e2, e3;
  logic          tick;

  assign limit = (clk_sel == 2'd1) ? DW'(PRE_A - 1) : DW'(PRE_B - 1);

  always_comb begin
    case (clk_sel)
      2'd0:    tick = run;
      2'd3:    tick = run && e2 && !e3;
      default: tick = run && (div_q >= limit);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      e1       <= 1'b0;
      e2       <= 1'b0;
      e3       <= 1'b0;
      cnt      <= '0;
      adv      <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      e1  <= ext_tick;
      e2  <= e1;
      e3  <= e2;
      adv <= tick;
      if (run) div_q <= (div_q >= limit) ? '0 : div_q + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
      if (tick && (&cnt)) ovf_flag <= 1'b1;
      else if (ovf_clr)   ovf_flag <= 1'b0;
    end
  end

  // R1: one step per tick, none otherwise
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 16'd1);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R2: wrap sets the flag, which then sticks
  a_r2_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt)) |=> ovf_flag);
  a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cnt,
  input  logic          adv,
  input  logic          kill,
  input  logic          cap_in,
  input  logic          mode_we,
  input  logic          val_we,
  input  logic [TW-1:0] wdata,
  input  logic          flag_clr,
  output logic          pin,
  output logic          flag,
  output logic [TW-1:0] value
);
  ch_mode_e      mode;
  logic          edge_r, edge_f, pol, center;
  logic [2:0]    wcode;
  logic [TW-1:0] stage;
  logic          raw;
  logic          s1, s2, s3;

  // named events for the assertions
  logic          is_pwm, is_hso, is_capt;
  logic [TW-1:0] cmp_mask, cmp_m;
  logic          boundary, match, freq_hit, cap_evt, flag_set;

  assign is_pwm   = (mode == M_PWM);
  assign is_hso   = (mode == M_HSO);
  assign is_capt  = (mode == M_CAPT);
  assign cmp_mask = pwm_mask(wcode);
  assign cmp_m    = value & cmp_mask;
  assign boundary = is_pwm && adv && ((cnt & cmp_mask) == '0);
  assign match    = adv && (cnt == value);
  assign freq_hit = adv && (cnt[7:0] == value[7:0]);
  assign cap_evt  = is_capt && ((edge_r && s2 && !s3) || (edge_f && !s2 && s3));
  assign flag_set = cap_evt || boundary ||
                    (match && (mode == M_SWT || is_hso));

  assign pin = (raw & ~kill) ^ pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= M_OFF;
      edge_r <= 1'b0;
      edge_f <= 1'b0;
      pol    <= 1'b0;
      center <= 1'b0;
      wcode  <= '0;
      stage  <= '0;
      value  <= '0;
      raw    <= 1'b0;
      flag   <= 1'b0;
      s1     <= 1'b0;
      s2     <= 1'b0;
      s3     <= 1'b0;
    end else begin
      s1 <= cap_in;
      s2 <= s1;
      s3 <= s2;
      if (mode_we) begin
        mode   <= ch_mode_e'(wdata[2:0]);
        edge_r <= wdata[3];
        edge_f <= wdata[4];
        pol    <= wdata[5];
        center <= wdata[6];
        wcode  <= wdata[9:7];
      end
      if (val_we) stage <= wdata;
      if (cap_evt)                 value <= cnt;
      else if (val_we && !is_pwm)  value <= wdata;
      else if (boundary)           value <= stage;
      else if (freq_hit && mode == M_FREQ)
        value[7:0] <= value[7:0] + value[15:8];
      if (mode_we) raw <= 1'b0;
      else begin
        case (mode)
          M_PWM:   raw <= pwm_level(cnt, value, wcode, center);
          M_HSO:   if (match) raw <= ~raw;
          M_FREQ:  if (freq_hit) raw <= ~raw;
          default: raw <= 1'b0;
        endcase
      end
      if (flag_set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  // R3: capture copies the timebase and flags
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (flag && value == $past(cnt)));
  // R4: flag sticks until cleared
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  // R6: toggle follows a match
  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hso && $past(is_hso) && $past(match) && !$past(mode_we)) |-> raw != $past(raw));
  // R8: zero compare never drives active
  a_r8_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm && $past(is_pwm) && $past(cmp_m) == '0 && !$past(mode_we)) |-> !raw);
  // R10: active compare only changes at the boundary
  a_r10_boundary_load: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm && $past(is_pwm) && !$past(boundary)) |-> $stable(value));
  // R12: kill forces inactive level
  a_r12_kill: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (pin == pol));
endmodule

// File: rtl/ccp_array.sv
module ccp_array
  import ccp_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int PRE_A = 4,
  parameter int PRE_B = 12,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        clk_sel,
  input  logic              ext_tick,
  input  logic              kill,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic              cfg_sel,
  input  logic [TW-1:0]     cfg_wdata,
  input  logic [NCH-1:0]    cap_in,
  input  logic [NCH-1:0]    flag_clr,
  input  logic              ovf_clr,
  output logic [TW-1:0]     count,
  output logic              ovf_flag,
  output logic [NCH-1:0]    ch_flag,
  output logic [NCH-1:0]    ch_out,
  output logic [TW*NCH-1:0] ch_value
);
  logic adv;

  ccp_timebase #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clk_sel  (clk_sel),
    .ext_tick (ext_tick),
    .ovf_clr  (ovf_clr),
    .cnt      (count),
    .adv      (adv),
    .ovf_flag (ovf_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = cfg_we && (cfg_ch == CHW'(i));

    ccp_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (count),
      .adv      (adv),
      .kill     (kill),
      .cap_in   (cap_in[i]),
      .mode_we  (hit && !cfg_sel),
      .val_we   (hit && cfg_sel),
      .wdata    (cfg_wdata),
      .flag_clr (flag_clr[i]),
      .pin      (ch_out[i]),
      .flag     (ch_flag[i]),
      .value    (ch_value[i*TW +: TW])
    );
  end
endmodule

// File: tb/ccp_array_tb.sv
module ccp_array_tb;
  logic        clk = 1'b0;
  logic        rst_n, run, ext_tick, kill, cfg_we, cfg_sel, ovf_clr;
  logic [1:0]  clk_sel, cfg_ch;
  logic [15:0] cfg_wdata, count;
  logic [2:0]  cap_in, flag_clr, ch_flag, ch_out;
  logic [47:0] ch_value;
  logic        ovf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ccp_array u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_sel(clk_sel), .ext_tick(ext_tick),
    .kill(kill), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cap_in(cap_in), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
    .count(count), .ovf_flag(ovf_flag), .ch_flag(ch_flag), .ch_out(ch_out),
    .ch_value(ch_value)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] val(input int i);
    return ch_value[i*16 +: 16];
  endfunction

  function automatic logic [15:0] mw(input logic [2:0] mode, input logic er, input logic ef,
                                     input logic pl, input logic ctr, input logic [2:0] code);
    return {6'd0, code, ctr, pl, ef, er, mode};
  endfunction

  function automatic int exp_ones(input int code, input int cmp, input bit ctr, input bit pl);
    int n, p, m, ones;
    n = (code == 4) ? 16 : 8 + code;
    p = 1 << n;
    m = cmp % p;
    ones = ctr ? ((m < 2) ? 0 : 2 * (m / 2)) : m;
    return pl ? p - ones : ones;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input bit sel, input logic [15:0] d);
    cfg_ch = 2'(ch); cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pwm_case(input int code, input int cmp, input bit ctr, input bit pl, input string tag);
    int p, ones;
    p = 1 << ((code == 4) ? 16 : 8 + code);
    wr(0, 0, mw(3'd5, 0, 0, pl, ctr, 3'(code)));
    wr(0, 1, 16'(cmp));
    waitn(2 * p);
    ones = 0;
    repeat (p) begin
      @(negedge clk);
      ones += int'(ch_out[0]);
    end
    chk(ones == exp_ones(code, cmp, ctr, pl), tag, ones, exp_ones(code, cmp, ctr, pl));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int k, t, c1, c2, c3, ones;
    logic [7:0] lo;
    logic prev;
    rst_n = 0; run = 0; clk_sel = 0; ext_tick = 0; kill = 0; cfg_we = 0; cfg_sel = 0;
    cfg_ch = 0; cfg_wdata = 0; cap_in = 0; flag_clr = 0; ovf_clr = 0;
    waitn(3);
    rst_n = 1;
    waitn(1);
    // R13 reset state
    chk(count == 0, "R13 count", count, 0);
    chk(ch_flag == 0 && ovf_flag == 0, "R13 flags", {ovf_flag, ch_flag}, 0);
    chk(ch_out == 0, "R13 pins", ch_out, 0);

    // R1 tick sources
    clk_sel = 2'd1; run = 1;
    waitn(40);
    chk(count == 10, "R1 div4", count, 10);
    clk_sel = 2'd2;
    waitn(48);
    chk(count == 14, "R1 div12", count, 14);
    run = 0;
    waitn(20);
    chk(count == 14, "R1 hold", count, 14);
    run = 1; clk_sel = 2'd3;
    repeat (5) begin
      ext_tick = 1; waitn(3);
      ext_tick = 0; waitn(3);
    end
    waitn(4);
    chk(count == 19, "R1 ext", count, 19);
    clk_sel = 2'd0;

    // R3 capture, rising only
    wr(0, 0, mw(3'd1, 1, 0, 0, 0, 0));
    waitn(2);
    k = count; cap_in[0] = 1;
    waitn(3);
    chk(val(0) == 16'(k + 2), "R3 rise value", val(0), k + 2);
    chk(ch_flag[0] == 1, "R3 rise flag", ch_flag[0], 1);
    waitn(10);
    chk(ch_flag[0] == 1, "R4 sticky", ch_flag[0], 1);
    flag_clr[0] = 1; waitn(1); flag_clr[0] = 0;
    chk(ch_flag[0] == 0, "R4 clear", ch_flag[0], 0);
    cap_in[0] = 0;
    waitn(6);
    chk(ch_flag[0] == 0 && val(0) == 16'(k + 2), "R3 falling ignored", val(0), k + 2);
    // falling only
    wr(0, 0, mw(3'd1, 0, 1, 0, 0, 0));
    cap_in[0] = 1;
    waitn(6);
    chk(ch_flag[0] == 0, "R3 rising ignored", ch_flag[0], 0);
    k = count; cap_in[0] = 0;
    waitn(3);
    chk(val(0) == 16'(k + 2) && ch_flag[0], "R3 fall value", val(0), k + 2);

    // R5 timer compare on ch1
    wr(1, 0, mw(3'd2, 0, 0, 0, 0, 0));
    t = (count + 20) & 16'hFFFF;
    wr(1, 1, 16'(t));
    c1 = -1;
    for (int i = 0; i < 40 && c1 < 0; i++) begin
      @(negedge clk);
      if (ch_flag[1]) c1 = count;
    end
    chk(c1 == ((t + 1) & 16'hFFFF), "R5 match time", c1, t + 1);
    chk(ch_out[1] == 0, "R5 pin idle", ch_out[1], 0);

    // R6 toggle on ch2
    wr(2, 0, mw(3'd3, 0, 0, 0, 0, 0));
    t = (count + 15) & 16'hFFFF;
    wr(2, 1, 16'(t));
    c1 = -1;
    for (int i = 0; i < 40 && c1 < 0; i++) begin
      @(negedge clk);
      if (ch_out[2]) c1 = count;
    end
    chk(c1 == ((t + 1) & 16'hFFFF), "R6 toggle time", c1, t + 1);
    chk(ch_flag[2] == 1, "R6 flag", ch_flag[2], 1);

    // R7 frequency output on ch2
    wr(2, 0, mw(3'd4, 0, 0, 0, 0, 0));
    lo = 8'(count + 10);
    wr(2, 1, {8'd5, lo});
    prev = ch_out[2]; c1 = -1; c2 = -1; c3 = -1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ch_out[2] != prev) begin
        if (c1 < 0) c1 = count[7:0];
        else if (c2 < 0) c2 = count[7:0];
        else if (c3 < 0) c3 = count[7:0];
      end
      prev = ch_out[2];
    end
    chk(c1 == int'(8'(lo + 1)), "R7 first toggle", c1, 8'(lo + 1));
    chk(c2 == int'(8'(lo + 6)) && c3 == int'(8'(lo + 11)), "R7 period", c3, 8'(lo + 11));

    // R8 edge-aligned sweep
    pwm_case(0, 0, 0, 0, "R8 e8 cmp0");
    pwm_case(0, 1, 0, 0, "R8 e8 cmp1");
    pwm_case(0, 100, 0, 0, "R8 e8 cmp100");
    pwm_case(0, 255, 0, 0, "R8 e8 cmp255");
    pwm_case(0, 16'h1F40, 0, 0, "R8 e8 masked");
    pwm_case(1, 300, 0, 0, "R8 e9");
    pwm_case(2, 700, 0, 0, "R8 e10");
    pwm_case(3, 1500, 0, 0, "R8 e11");
    // R9 centre-aligned sweep
    pwm_case(0, 1, 1, 0, "R9 c8 cmp1");
    pwm_case(0, 2, 1, 0, "R9 c8 cmp2");
    pwm_case(0, 3, 1, 0, "R9 c8 cmp3");
    pwm_case(0, 128, 1, 0, "R9 c8 cmp128");
    pwm_case(0, 255, 1, 0, "R9 c8 cmp255");
    pwm_case(1, 301, 1, 0, "R9 c9");
    pwm_case(3, 1001, 1, 0, "R9 c11");
    // R11 polarity
    pwm_case(0, 0, 0, 1, "R11 inv cmp0");
    pwm_case(0, 64, 0, 1, "R11 inv cmp64");

    // R10 shadow load at period boundary (8-bit, value now 64)
    pwm_case(0, 64, 0, 0, "R10 setup");
    while (count[7:0] != 8'h10) @(negedge clk);
    wr(0, 1, 16'h0090);
    chk(val(0) == 16'h0040, "R10 held after write", val(0), 16'h40);
    while (count[7:0] != 8'h00) @(negedge clk);
    chk(val(0) == 16'h0040, "R10 held at wrap", val(0), 16'h40);
    waitn(1);
    chk(val(0) == 16'h0090, "R10 loaded", val(0), 16'h90);

    // R12 kill
    kill = 1; #1;
    chk(ch_out[0] == 0, "R12 immediate", ch_out[0], 0);
    ones = 0;
    repeat (256) begin @(negedge clk); ones += int'(ch_out[0]); end
    chk(ones == 0, "R12 kill pol0", ones, 0);
    wr(0, 0, mw(3'd5, 0, 0, 1, 0, 0));
    ones = 0;
    repeat (256) begin @(negedge clk); ones += int'(ch_out[0]); end
    chk(ones == 256, "R12 kill pol1", ones, 256);
    kill = 0;
    waitn(2);
    ones = 0;
    repeat (256) begin @(negedge clk); ones += int'(ch_out[0]); end
    chk(ones == 256 - 144, "R11 R12 release", ones, 112);

    // R2 overflow
    while (count != 16'hFFFF) @(negedge clk);
    chk(ovf_flag == 0, "R2 before wrap", ovf_flag, 0);
    waitn(1);
    chk(count == 0 && ovf_flag == 1, "R2 wrap", ovf_flag, 1);
    waitn(5);
    chk(ovf_flag == 1, "R2 sticky", ovf_flag, 1);
    ovf_clr = 1; waitn(1); ovf_clr = 0;
    chk(ovf_flag == 0, "R2 clear", ovf_flag, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule